// File: doc/BRIEF.md
# Watermark-and-Compress Frame Sequencer

This block is the control state machine of an encoder that stamps a transformed logo into each video frame and then compresses it. For one frame it runs a fixed chain of data-movement stages. Each stage hands a one-cycle start to its processing unit and holds until that unit reports done. The stages are: forward transform of the picture and the logo, inverse transform of the stamped coefficients back to the frame store, motion estimation, transform with quantization, coefficient reordering, and entropy coding. The frame type, latched at frame start, decides whether motion estimation runs and which form it takes.

The datapath units sit outside the block. The sequencer only drives their start strobes, watches their done strobes, and publishes a 3-bit stage code that the surrounding buffer multiplexers decode. After the entropy stage the machine spends one cycle in a closing stage, pulses its end-of-frame output, and goes back to waiting in the first stage.

Top module: `wm_frame_seq`

## Requirements
- R1: After reset the block waits in stage 0 with `stage_sel` = 0, all `unit_start` bits low and `frame_end` low.
- R2: When the block is waiting in stage 0 and `frame_start` is sampled high, it latches `frame_type`. On the next cycle it pulses `unit_start[0]`.
- R3: The start bits are: bit 0 forward transform, bit 1 inverse transform, bit 2 P-frame motion estimation, bit 3 B-frame motion estimation, bit 4 transform/quantize, bit 5 zigzag reorder, bit 6 entropy coder. On entry to a stage, that stage's start bits are high for exactly the first cycle in the stage.
- R4: A stage holds until every unit it started has returned its `unit_done` bit. A done may arrive in the same cycle as its start. Done bits from units the stage is not waiting on have no effect.
- R5: The `stage_sel` codes are 0 forward transform, 1 inverse transform, 2 P motion estimation, 3 B motion estimation, 4 transform/quantize, 5 zigzag, 6 entropy, 7 end. After stage 1 the block goes to stage 2, 3 or 4, and stages 2 and 3 lead to 4, 4 to 5, 5 to 6 and 6 to 7.
- R6: `frame_type` 00 (I) and the reserved code 11 skip motion estimation and go from stage 1 to stage 4. 01 (P) enters stage 2 and starts only bit 2.
- R7: `frame_type` 10 (B) enters stage 3. It starts bits 3 and 1 in the same cycle and leaves the stage only when both have reported done, whatever their order.
- R8: Stage 7 lasts one cycle with `frame_end` high, so `frame_end` is a one-cycle pulse. The block then waits in stage 0.
- R9: `frame_start` is ignored while a frame is in progress, including the end stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Request to process one frame |
| frame_type | input | 2 | 00 I, 01 P, 10 B, 11 treated as I |
| unit_done | input | 7 | Completion strobes from the stage units |
| unit_start | output | 7 | One-cycle start strobes to the stage units |
| stage_sel | output | 3 | Current stage code for buffer routing |
| frame_end | output | 1 | One-cycle end-of-frame pulse |

## Verification
The embedded properties check, on every cycle, that start strobes last a single cycle inside a stage and that a stage never moves without some done. They also check that the end pulse is single and followed by stage 0, that quantize only hands over to zigzag, that motion estimation stages never appear for an I frame, and that the B stage waits for its missing done. Only the bench scenarios can show the full route chosen for each frame type, correct handling of the two B-stage dones arriving in different orders, dones that arrive with zero latency, dones that are stray or unrelated, and frame requests made mid-frame. These are compared cycle by cycle against an independent route-list model.

// File: rtl/wm_frame_seq.sv
module wm_frame_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_start,
  input  logic [1:0] frame_type,
  input  logic [6:0] unit_done,
  output logic [6:0] unit_start,
  output logic [2:0] stage_sel,
  output logic       frame_end
);

  typedef enum logic [2:0] {
    ST_FWD = 3'd0, ST_INV = 3'd1, ST_MEP = 3'd2, ST_MEB = 3'd3,
    ST_QNT = 3'd4, ST_ZIG = 3'd5, ST_ENT = 3'd6, ST_END = 3'd7
  } stage_t;

  localparam logic [1:0] FT_P = 2'b01;
  localparam logic [1:0] FT_B = 2'b10;

  stage_t     state, nxt;
  logic       busy;
  logic [1:0] ftype;
  logic [6:0] start_q, pend, left;

  function automatic logic [6:0] units_of(input stage_t s);
    case (s)
      ST_FWD:  units_of = 7'b0000001;
      ST_INV:  units_of = 7'b0000010;
      ST_MEP:  units_of = 7'b0000100;
      ST_MEB:  units_of = 7'b0001010;
      ST_QNT:  units_of = 7'b0010000;
      ST_ZIG:  units_of = 7'b0100000;
      ST_ENT:  units_of = 7'b1000000;
      default: units_of = 7'b0000000;
    endcase
  endfunction

  assign left = pend & ~unit_done;

  always_comb begin
    case (state)
      ST_FWD:  nxt = ST_INV;
      ST_INV:  nxt = (ftype == FT_P) ? ST_MEP : (ftype == FT_B) ? ST_MEB : ST_QNT;
      ST_MEP:  nxt = ST_QNT;
      ST_MEB:  nxt = ST_QNT;
      ST_QNT:  nxt = ST_ZIG;
      ST_ZIG:  nxt = ST_ENT;
      ST_ENT:  nxt = ST_END;
      default: nxt = ST_FWD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_FWD;
      busy    <= 1'b0;
      ftype   <= 2'b00;
      start_q <= '0;
      pend    <= '0;
    end else begin
      start_q <= '0;
      if (state == ST_END) begin
        state <= ST_FWD;
        busy  <= 1'b0;
      end else if (!busy) begin
        if (frame_start) begin
          busy    <= 1'b1;
          ftype   <= frame_type;
          start_q <= units_of(ST_FWD);
          pend    <= units_of(ST_FWD);
        end
      end else if (left == '0) begin
        state   <= nxt;
        start_q <= units_of(nxt);
        pend    <= units_of(nxt);
      end else begin
        pend <= left;
      end
    end
  end

  assign unit_start = start_q;
  assign stage_sel  = state;
  assign frame_end  = (state == ST_END);

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|unit_start) |=> (!$stable(stage_sel) || unit_start == '0)); // R3
  AST_HOLD_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && stage_sel != 3'd7 && unit_done == '0) |=> $stable(stage_sel)); // R4
  AST_QNT_TO_ZIG: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_sel == 3'd4) |=> (stage_sel == 3'd4 || stage_sel == 3'd5)); // R5
  AST_I_NO_ME: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_sel == 3'd2 || stage_sel == 3'd3) |-> (ftype == FT_P || ftype == FT_B)); // R6
  AST_B_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_sel == 3'd3 && pend[3] && !unit_done[3]) |=> stage_sel == 3'd3); // R7
  AST_END_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (!frame_end && stage_sel == 3'd0)); // R8

endmodule

// File: tb/test_wm_frame_seq.sv
module test_wm_frame_seq;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_start = 1'b0;
  logic [1:0] frame_type = 2'b00;
  logic [6:0] unit_done = '0;
  logic [6:0] unit_start;
  logic [2:0] stage_sel;
  logic       frame_end;

  wm_frame_seq i_wm_frame_seq (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_type(frame_type),
    .unit_done(unit_done), .unit_start(unit_start), .stage_sel(stage_sel),
    .frame_end(frame_end)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_run = 0, n_fail = 0, cycles = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: a route list built per frame
  int        route[$];
  int        pos = 0;
  bit        active = 0;
  bit [6:0]  outst = '0;
  int        m_sel = 0;
  bit [6:0]  m_start = '0;

  function automatic bit [6:0] want(input int s);
    case (s)
      0: return 7'h01; 1: return 7'h02; 2: return 7'h04; 3: return 7'h0A;
      4: return 7'h10; 5: return 7'h20; 6: return 7'h40; default: return 7'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    m_start = '0;
    if (!rst_n) begin
      active = 0; m_sel = 0; outst = '0;
    end else if (!active) begin
      if (frame_start) begin
        route = {0, 1};
        if (frame_type == 2'b01) route.push_back(2);
        if (frame_type == 2'b10) route.push_back(3);
        route.push_back(4); route.push_back(5); route.push_back(6); route.push_back(7);
        pos = 0; active = 1; outst = want(0); m_start = outst; m_sel = 0;
      end
    end else if (m_sel == 7) begin
      active = 0; m_sel = 0;
    end else begin
      outst = outst & ~unit_done;
      if (outst == '0) begin
        pos++; m_sel = route[pos]; outst = want(m_sel); m_start = outst;
      end
    end
  end

  // unit responders
  int lat[7] = '{1, 1, 1, 1, 1, 1, 1};
  int cnt[7] = '{0, 0, 0, 0, 0, 0, 0};
  bit [6:0] noise = '0;
  int n_idct = 0, n_mep = 0, n_meb = 0, n_end = 0;

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk(stage_sel == m_sel[2:0], "R5 stage_sel", stage_sel, m_sel);
      chk(unit_start == m_start, "R3 unit_start", unit_start, m_start);
      chk(frame_end == (m_sel == 7), "R8 frame_end", frame_end, m_sel == 7);
      if (unit_start[1]) n_idct++;
      if (unit_start[2]) n_mep++;
      if (unit_start[3]) n_meb++;
      if (frame_end) n_end++;
    end
    for (int u = 0; u < 7; u++) begin
      bit d;
      d = 1'b0;
      if (cnt[u] > 0) begin
        cnt[u]--;
        if (cnt[u] == 0) d = 1'b1;
      end
      if (unit_start[u]) begin
        if (lat[u] == 0) d = 1'b1;
        else cnt[u] = lat[u];
      end
      unit_done[u] = d | noise[u];
    end
    if (cycles > 150000 && !done_flag) begin
      done_flag = 1;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic set_lat(input int v);
    for (int u = 0; u < 7; u++) lat[u] = v;
  endtask

  task automatic run_frame(input logic [1:0] ft, input bit poke);
    n_idct = 0; n_mep = 0; n_meb = 0; n_end = 0;
    @(negedge clk); frame_start = 1'b1; frame_type = ft;
    @(negedge clk); frame_start = poke; frame_type = ~ft;   // R9 mid-frame request
    for (int k = 0; k < 500 && !frame_end; k++) @(negedge clk);
    frame_start = 1'b0;
    @(negedge clk);
    chk(n_end == 1, "R8 end pulses", n_end, 1);
    chk(n_mep == (ft == 2'b01), "R6 P-ME starts", n_mep, ft == 2'b01);
    chk(n_meb == (ft == 2'b10), "R7 B-ME starts", n_meb, ft == 2'b10);
    chk(n_idct == ((ft == 2'b10) ? 2 : 1), "R7 IDCT starts", n_idct, (ft == 2'b10) ? 2 : 1);
    chk(stage_sel == 3'd0 && unit_start == '0, "R8 back to wait", stage_sel, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(stage_sel == 3'd0, "R1 reset stage", stage_sel, 0);
    chk(unit_start == '0, "R1 reset starts", unit_start, 0);
    chk(frame_end == 1'b0, "R1 reset end", frame_end, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(unit_start == '0 && stage_sel == 3'd0, "R2 waits for request", unit_start, 0);

    set_lat(1);  run_frame(2'b00, 1'b0);  // R6 I frame
    set_lat(3);  run_frame(2'b01, 1'b1);  // R6 P frame, R9
    set_lat(2); lat[3] = 5; lat[1] = 1; run_frame(2'b10, 1'b0);  // R7 IDCT first
    set_lat(2); lat[3] = 1; lat[1] = 6; run_frame(2'b10, 1'b1);  // R7 ME first
    set_lat(0);  run_frame(2'b10, 1'b0);  // R4 zero-latency done
    set_lat(0);  run_frame(2'b11, 1'b0);  // R6 reserved code
    set_lat(4); noise = 7'h40;  run_frame(2'b01, 1'b0);  // R4 stray done ignored
    noise = 7'h00;
    set_lat(1);  run_frame(2'b00, 1'b1);

    // R9: request held through end stage starts nothing early
    set_lat(1);
    @(negedge clk); frame_start = 1'b1; frame_type = 2'b00;
    for (int k = 0; k < 500 && !frame_end; k++) @(negedge clk);
    @(negedge clk);
    chk(stage_sel == 3'd0 && unit_start == '0, "R9 no start from end stage", unit_start, 0);
    @(negedge clk);
    chk(unit_start == 7'h01, "R2 start after wait", unit_start, 1);
    frame_start = 1'b0;
    for (int k = 0; k < 500 && !frame_end; k++) @(negedge clk);
    repeat (2) @(negedge clk);

    if (!done_flag) begin
      done_flag = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule